// File: doc/BRIEF.md
# Interrupt Concentrator with Set/Clear Mask

This block gathers level-sensitive interrupt requests from six on-chip sources and merges them into one host interrupt line. The sources are two I2C masters, an SPI flash controller, two DMA channels and a common-interface controller. Each source has an enable bit in a per-source mask. Software changes the mask through two write-only aliases. One alias sets bits for each 1 written. The other clears bits for each 1 written. Because of this, no read-modify-write sequence is ever needed.

A global enable sits between the merged request and the host line. A global status flag reports whether any masked request is pending, and it does so even while the line is gated off. Software polls that flag and then reads the source register to find which sources are pending. It services one source per entry, in fixed priority order. The block also provides that choice directly as an index output with a valid flag.

Access is through a simple 32-bit register bus with byte addresses. Reads are combinational from the address. A write takes effect at the rising clock edge on which the write enable is high.

Top module: `irq_concentrator`

## Requirements
- R1: After synchronous active-low reset, the mask is all zeros and the global enable is off. As a result, `host_irq` and `top_valid` are 0, and every register reads as 0, even while all requests are high.
- R2: A write to the mask-set alias at offset 0x48 sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. The mask reads back at both 0x48 and 0x4C in bits 5:0. Bits 31:6 read 0, even after 0xFFFF is written.
- R3: A write to the mask-clear alias at offset 0x4C clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Writing 0xFFFF there disables every source.
- R4: The source register at offset 0x44 reads the raw requests ANDed with the mask. The bit order is I2C0 = bit 0, I2C1 = bit 1, SPI = bit 2, DMA0 = bit 3, DMA1 = bit 4, CI = bit 5. Bits 31:6 read 0. The value follows the request inputs in the same cycle.
- R5: The global enable is bit 7 of the register at offset 0x50, and a write loads it from write-data bit 7. Writing 0x80 sets it and writing 0 clears it. The register reads 0x80 when the enable is on and 0 when it is off. `host_irq` is 1 exactly when the enable is on and at least one masked request is pending.
- R6: The global status register at offset 0x40 reads 0x80 whenever at least one masked request is pending, regardless of the global enable. Otherwise it reads 0.
- R7: `top_valid` is 1 when any masked request is pending. `top_idx` then gives the lowest-numbered pending masked source, so the priority order is I2C0, I2C1, SPI, DMA0, DMA1, CI. When nothing is pending, `top_idx` is 0.
- R8: Writes to the read-only offsets 0x40 and 0x44, and writes to unmapped offsets, change neither the mask nor the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_req | input | NSRC (6) | Level requests from the sources, bit order as in R4 |
| host_irq | output | 1 | Host interrupt line |
| top_idx | output | 3 | Index of the highest-priority pending masked source |
| top_valid | output | 1 | A masked source is pending |

## Verification
On every cycle, the assertions check several relations. The host line never rises without both the global enable and a masked request behind it. The priority index always points at a source that is both requesting and enabled. A set or clear write has its effect on the next cycle. Writes to read-only or unmapped offsets leave the mask and enable untouched. The bench's scenarios cover what is not a simple cycle-to-cycle implication: the exact lowest-index choice among many request patterns, the zero upper bits of the source and mask reads, the status flag while the line is gated off, and the reset state observed through the bus.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt concentrator.
// Offsets are byte addresses on the register bus. The global status and
// enable offsets and their bit 7 are fixed because host software decodes them.
package irqc_pkg;
    localparam int unsigned OFS_STATUS  = 32'h40;
    localparam int unsigned OFS_SOURCE  = 32'h44;
    localparam int unsigned OFS_MSET    = 32'h48;
    localparam int unsigned OFS_MCLR    = 32'h4C;
    localparam int unsigned OFS_GENABLE = 32'h50;
    localparam int unsigned FLAG_BIT    = 7;

    // Source bit order, which is also the service priority (bit 0 first).
    typedef enum logic [2:0] {
        SRC_I2C0 = 3'd0,
        SRC_I2C1 = 3'd1,
        SRC_SPI  = 3'd2,
        SRC_DMA0 = 3'd3,
        SRC_DMA1 = 3'd4,
        SRC_CI   = 3'd5
    } irqc_src_e;
endpackage

// File: rtl/irqc_mask_reg.sv
// Per-source enable mask.
// Holds NSRC enable bits that are changed only through set and clear vectors.
// If a bit is set and cleared in the same cycle, clear wins.
// Assumes: set/clr vectors are already qualified by the bus decode.
module irqc_mask_reg #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] mask_q
);
    // Update the mask: OR in the set bits, then remove the clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_vec) & ~clr_vec;
    end
endmodule

// File: rtl/irqc_gate.sv
// Request gating.
// ANDs each raw request with its mask bit, merges the results, and gates
// the merged request with the global enable to form the host line.
// Assumes: requests are level signals that are already synchronous to clk.
module irqc_gate #(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] mask,
    input  logic            gen,
    output logic [NSRC-1:0] masked,
    output logic            any,
    output logic            line
);
    // One AND gate per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_and
        assign masked[g] = req[g] & mask[g];
    end

    // Merge the masked requests and gate them with the global enable.
    always_comb begin
        any  = |masked;
        line = any & gen;
    end
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority selector.
// Returns the index of the lowest-numbered set bit and a valid flag.
// Assumes: NSRC >= 2 so that IDX_W is at least 1.
module irqc_prio #(
    parameter int NSRC  = 6,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    // Scan from the highest index down, so the lowest set bit is the last one written.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_regfile.sv
// Register bus decode for the concentrator.
// Holds the global enable flag, turns writes to the set and clear aliases
// into mask update vectors, and drives the combinational read mux.
// Assumes: single-cycle writes, and word-aligned byte addresses compared in full.
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NSRC   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic [NSRC-1:0]   mask_q,
    input  logic [NSRC-1:0]   masked,
    input  logic              any,
    output logic              gen_q,
    output logic [NSRC-1:0]   set_vec,
    output logic [NSRC-1:0]   clr_vec,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SOURCE  = ADDR_W'(OFS_SOURCE);
    localparam logic [ADDR_W-1:0] A_MSET    = ADDR_W'(OFS_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR    = ADDR_W'(OFS_MCLR);
    localparam logic [ADDR_W-1:0] A_GENABLE = ADDR_W'(OFS_GENABLE);
    localparam int               PAD_W     = 32 - NSRC;

    logic wr_gen;

    // Unused write-data bits, grouped under one name.
    wire unused_wdata = ^bus_wdata;

    // Decode writes into mask update vectors and a load of the enable flag.
    always_comb begin
        set_vec = (bus_we && bus_addr == A_MSET) ? bus_wdata[NSRC-1:0] : '0;
        clr_vec = (bus_we && bus_addr == A_MCLR) ? bus_wdata[NSRC-1:0] : '0;
        wr_gen  = bus_we && (bus_addr == A_GENABLE);
    end

    // Global enable flag, loaded from write-data bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n)      gen_q <= 1'b0;
        else if (wr_gen) gen_q <= bus_wdata[FLAG_BIT];
    end

    // Read mux. Unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS:       bus_rdata[FLAG_BIT] = any;
            A_SOURCE:       bus_rdata = {{PAD_W{1'b0}}, masked};
            A_MSET, A_MCLR: bus_rdata = {{PAD_W{1'b0}}, mask_q};
            A_GENABLE:      bus_rdata[FLAG_BIT] = gen_q;
            default:        bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_concentrator.sv
// Interrupt concentrator top.
// Merges NSRC level requests into one host line. The block provides a per-source
// set/clear mask, a global enable, a global status flag, a source register and
// a fixed-priority index.
// Assumes: requests are synchronous to clk, and the sources clear their own requests.
module irq_concentrator #(
    parameter int ADDR_W = 8,
    parameter int NSRC   = 6,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   src_req,
    output logic              host_irq,
    output logic [IDX_W-1:0]  top_idx,
    output logic              top_valid
);
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] masked;
    logic            any;
    logic            gen_q;

    irqc_regfile #(.ADDR_W(ADDR_W), .NSRC(NSRC)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .mask_q(mask_q), .masked(masked), .any(any),
        .gen_q(gen_q), .set_vec(set_vec), .clr_vec(clr_vec),
        .bus_rdata(bus_rdata)
    );

    irqc_mask_reg #(.NSRC(NSRC)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec), .mask_q(mask_q)
    );

    irqc_gate #(.NSRC(NSRC)) gate_i (
        .req(src_req), .mask(mask_q), .gen(gen_q),
        .masked(masked), .any(any), .line(host_irq)
    );

    irqc_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) prio_i (
        .pend(masked), .idx(top_idx), .valid(top_valid)
    );
endmodule

// File: rtl/irqc_checker.sv
// Assertion checker for irq_concentrator, attached by bind.
// It observes the ports and the mask and enable state.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NSRC   = 6,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [NSRC-1:0]   src_req,
    input logic [NSRC-1:0]   mask_q,
    input logic              gen_q,
    input logic              host_irq,
    input logic [IDX_W-1:0]  top_idx,
    input logic              top_valid
);
    // R1: reset empties the mask and turns the enable off.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && !gen_q));

    // R2: the set alias turns on every bit written as 1.
    a_r2_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MSET)) |=>
        ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R3: the clear alias turns off every bit written as 1.
    a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MCLR)) |=>
        ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R5: the line needs the enable and a masked request behind it.
    a_r5_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (gen_q && ((src_req & mask_q) != '0)));

    // R7: the index points at an enabled and requesting source.
    a_r7_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (src_req[top_idx] && mask_q[top_idx]));

    // R7: the line implies a valid index.
    a_r7_valid_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> top_valid);

    // R8: writes to read-only or unmapped offsets leave the state alone.
    a_r8_ro_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADDR_W'(OFS_MSET) && bus_addr != ADDR_W'(OFS_MCLR)
                && bus_addr != ADDR_W'(OFS_GENABLE)) |=>
        ($stable(mask_q) && $stable(gen_q)));
endmodule

bind irq_concentrator irqc_checker #(.ADDR_W(ADDR_W), .NSRC(NSRC), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .src_req(src_req), .mask_q(mask_q), .gen_q(gen_q),
    .host_irq(host_irq), .top_idx(top_idx), .top_valid(top_valid)
);

// File: tb/irq_concentrator_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design on every clock.
module irq_concentrator_tb_top;
    localparam int ADDR_W = 8;
    localparam int NSRC   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   src_req = '0;
    logic              host_irq;
    logic [2:0]        top_idx;
    logic              top_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state.
    int m_mask = 0;
    int m_gen  = 0;

    irq_concentrator #(.ADDR_W(ADDR_W), .NSRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .host_irq(host_irq), .top_idx(top_idx), .top_valid(top_valid)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, compare, then advance the model at the rising edge.
    task automatic step(string tag, bit rst, int addr, bit we, int wdata, int req);
        int pend, exp_rd, exp_idx;
        @(negedge clk);
        rst_n     = rst;
        bus_addr  = ADDR_W'(addr);
        bus_we    = we;
        bus_wdata = wdata;
        src_req   = NSRC'(req);
        #1;
        pend = req & m_mask;
        exp_idx = 0;
        for (int i = NSRC - 1; i >= 0; i--) if (pend[i]) exp_idx = i;
        case (addr)
            'h40:       exp_rd = (pend != 0) ? 'h80 : 0;
            'h44:       exp_rd = pend;
            'h48, 'h4C: exp_rd = m_mask;
            'h50:       exp_rd = m_gen ? 'h80 : 0;
            default:    exp_rd = 0;
        endcase
        check(tag, "host_irq", int'(host_irq), (m_gen != 0 && pend != 0) ? 1 : 0);
        check(tag, "top_valid", int'(top_valid), (pend != 0) ? 1 : 0);
        check(tag, "top_idx", int'(top_idx), exp_idx);
        check(tag, "rdata", int'(bus_rdata), exp_rd);
        @(posedge clk);
        if (!rst) begin
            m_mask = 0;
            m_gen  = 0;
        end else if (we) begin
            if (addr == 'h48) m_mask = m_mask | (wdata & 'h3F);
            if (addr == 'h4C) m_mask = m_mask & ~wdata & 'h3F;
            if (addr == 'h50) m_gen  = (wdata >> 7) & 1;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int lfsr;
        int sel;
        // R1: reset with all requests high, then read every register.
        step("R1", 0, 'h40, 0, 0, 'h3F);
        step("R1", 0, 'h40, 0, 0, 'h3F);
        step("R1", 1, 'h40, 0, 0, 'h3F);
        step("R1", 1, 'h44, 0, 0, 'h3F);
        step("R1", 1, 'h48, 0, 0, 'h3F);
        step("R1", 1, 'h50, 0, 0, 'h3F);
        // R2: set bits 0 and 2, other bits unchanged; upper bits stay zero.
        step("R2", 1, 'h48, 1, 'h05, 0);
        step("R2", 1, 'h48, 0, 0, 0);
        step("R2", 1, 'h48, 1, 'h10, 0);
        step("R2", 1, 'h4C, 0, 0, 0);
        step("R2", 1, 'h48, 1, 'hFFFF, 0);
        step("R2", 1, 'h48, 0, 0, 0);
        // R3: clear selected bits, then clear all with 0xFFFF.
        step("R3", 1, 'h4C, 1, 'h0A, 0);
        step("R3", 1, 'h48, 0, 0, 0);
        step("R3", 1, 'h4C, 1, 'hFFFF, 'h3F);
        step("R3", 1, 'h44, 0, 0, 'h3F);
        // R4: source register follows the requests through the mask.
        step("R4", 1, 'h48, 1, 'h2B, 'h3F);
        step("R4", 1, 'h44, 0, 0, 'h3F);
        step("R4", 1, 'h44, 0, 0, 'h14);
        step("R4", 1, 'h44, 0, 0, 'h20);
        // R6: status flag while the line is gated off.
        step("R6", 1, 'h40, 0, 0, 'h08);
        step("R6", 1, 'h40, 0, 0, 'h04);
        // R5: enable, then disable, with a pending request.
        step("R5", 1, 'h50, 1, 'h80, 'h08);
        step("R5", 1, 'h50, 0, 0, 'h08);
        step("R5", 1, 'h40, 0, 0, 'h00);
        step("R5", 1, 'h50, 1, 'h7F, 'h01);
        step("R5", 1, 'h50, 0, 0, 'h01);
        step("R5", 1, 'h50, 1, 'h80, 0);
        // R7: priority order with every source enabled.
        step("R7", 1, 'h48, 1, 'h3F, 'h30);
        step("R7", 1, 'h44, 0, 0, 'h30);
        step("R7", 1, 'h44, 0, 0, 'h3E);
        step("R7", 1, 'h44, 0, 0, 'h24);
        step("R7", 1, 'h44, 0, 0, 'h3F);
        step("R7", 1, 'h44, 0, 0, 'h20);
        // R8: writes to read-only and unmapped offsets change nothing.
        step("R8", 1, 'h40, 1, 'hFFFF_FFFF, 'h01);
        step("R8", 1, 'h44, 1, 'h0, 'h01);
        step("R8", 1, 'h70, 1, 'hFFFF_FFFF, 'h01);
        step("R8", 1, 'h48, 0, 0, 'h01);
        step("R8", 1, 'h50, 0, 0, 'h01);
        // Mixed traffic from an LFSR across all offsets (R2 R3 R4 R5 R6 R7 R8).
        lfsr = 'h1ACE;
        for (int k = 0; k < 400; k++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
            sel = lfsr & 7;
            step("R7", 1, 'h40 + 4 * (sel % 6), (lfsr >> 3) & 1, ((lfsr >> 4) & 'h3F) | ((lfsr & 'h100) ? 'h80 : 0), (lfsr >> 8) & 'h3F);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule